// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit memory address for one operand access of a banked 8/16-bit processor. The address space is split into 256 banks of 64 KiB. Each class of access follows its own bank rule:

- Program fetch stays inside the current program bank.
- Direct page and stack accesses always land in bank zero.
- Data-bank indexed accesses may carry into the following bank.
- Long operands and indirect long pointers carry their own bank and never use the data bank.

The instruction decoder pulses `start` with a mode code, the raw operand and the current register file values. For every mode except indirect long, the registered address appears one cycle later with a one-cycle `done` pulse. For indirect long, a small sequencer first fetches a three-byte pointer from direct page through a byte-wide request/valid read port. It then adds the Y index to the pointer and pulses `done`. While a pointer fetch is in progress, new `start` pulses are ignored. The Y value and the index-width flag are captured when the pointer fetch is launched.

Top module: `bank_addr_gen`

## Requirements
- R1: Mode 0 (program step) gives `{pbr, pc+1}`, where the 16-bit sum wraps and the bank is always `pbr` (01:FFFF steps to 01:0000).
- R2: Mode 1 (direct) gives bank $00 with offset `dpr + operand[7:0]`, wrapping in 16 bits, whatever `dbr` holds. For example, `dpr`=$C200 and operand $00 give $00C200.
- R3: Mode 2 (direct, X indexed) gives bank $00 with offset `dpr + operand[7:0] + X`, wrapping in 16 bits.
- R4: Mode 3 (stack) gives `{8'h00, sp}` regardless of `dbr`.
- R5: Modes 4 (absolute, X) and 5 (absolute, Y) give `{dbr, operand[15:0]} + index` as a 24-bit sum. A carry out of the low 16 bits increments the bank, and the sum wraps modulo 2^24. For example, `dbr`=$01, X=$0002 and operand $8000 give $018002.
- R6: Mode 6 (long, X indexed) gives `operand[23:0] + X` modulo 2^24 and ignores `dbr`. For example, $02FFFF with X=$FFFF gives $03FFFE.
- R7: When `idx8` is 1, bits 15:8 of X and Y are treated as zero in every indexed mode.
- R8: Mode 7 (indirect long, Y indexed) reads three bytes, low byte first, at bank $00 offsets P, P+1 and P+2, where P = `dpr + operand[7:0]` and each offset wraps in 16 bits. `mem_req` stays high with `mem_addr` stable until `mem_valid` is seen, and the read data is taken in that same cycle.
- R9: In mode 7, the result is `{byte2, byte1, byte0} + Y` modulo 2^24, using the Y value captured at launch, with `dbr` ignored.
- R10: `done` is a single-cycle pulse. It comes one cycle after an accepted `start` in modes 0–6, and two cycles after the third pointer byte in mode 7. A `start` during a pointer fetch has no effect.
- R11: After synchronous reset, `done`, `mem_req`, `mem_addr` and `addr_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation |
| mode | input | 3 | Addressing mode code (0–7, see requirements) |
| operand | input | 24 | Instruction operand; 8, 16 or 24 low bits are used depending on the mode |
| pc | input | 16 | Program counter |
| pbr | input | 8 | Program bank |
| dbr | input | 8 | Data bank |
| dpr | input | 16 | Direct page base |
| sp | input | 16 | Stack pointer |
| xr | input | 16 | X index register |
| yr | input | 16 | Y index register |
| idx8 | input | 1 | 1 = 8-bit index registers |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 8 | Read data byte |
| addr_out | output | 24 | Computed effective address (registered) |
| done | output | 1 | One-cycle pulse: `addr_out` is valid |

## Verification
Each mode is driven with a plain in-bank operand and then with an operand chosen to sit on a wrap point. Comparing the two separates a bank that carries (data-bank indexed and long modes) from one that is pinned (program step, direct page, stack). The same indexed operands are repeated with a nonzero upper index byte under `idx8`, which exposes a missing mask. Indirect long is run once with a pointer well inside direct page and once with a pointer straddling $FFFF, so that byte order, per-byte offset wrap and the zero bank of the reads all show at the read port. A second `start` during a fetch is used to confirm that it causes neither an extra `done` nor a different result.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    AM_PC_STEP = 3'd0,
    AM_DIR     = 3'd1,
    AM_DIR_X   = 3'd2,
    AM_STACK   = 3'd3,
    AM_ABS_X   = 3'd4,
    AM_ABS_Y   = 3'd5,
    AM_LONG_X  = 3'd6,
    AM_IND_LY  = 3'd7
  } amode_t;

endpackage

// File: rtl/eag_index_sel.sv
module eag_index_sel #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         narrow,
  output logic [W-1:0] eff
);
  localparam int HALF = W / 2;

  assign eff = narrow ? {{(W-HALF){1'b0}}, raw[HALF-1:0]} : raw;

endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8
) (
  input  amode_t                    mode,
  input  logic [OFS_W+BANK_W-1:0]   operand,
  input  logic [OFS_W-1:0]          pc,
  input  logic [BANK_W-1:0]         pbr,
  input  logic [BANK_W-1:0]         dbr,
  input  logic [OFS_W-1:0]          dpr,
  input  logic [OFS_W-1:0]          sp,
  input  logic [OFS_W-1:0]          xi,
  input  logic [OFS_W-1:0]          yi,
  output logic [OFS_W+BANK_W-1:0]   ea,
  output logic [OFS_W-1:0]          ptr_base
);
  localparam int ADDR_W = OFS_W + BANK_W;
  localparam int DP_W   = 8;

  logic [OFS_W-1:0]  dp_sum;
  logic [OFS_W-1:0]  dp_x_sum;
  logic [OFS_W-1:0]  pc_next;
  logic [ADDR_W-1:0] bank_base;
  logic [ADDR_W-1:0] abs_x_sum;
  logic [ADDR_W-1:0] abs_y_sum;
  logic [ADDR_W-1:0] long_x_sum;

  // Offset-only sums wrap at 16 bits; bank-carrying sums use the full width.
  assign dp_sum     = dpr + OFS_W'(operand[DP_W-1:0]);
  assign dp_x_sum   = dp_sum + xi;
  assign pc_next    = pc + OFS_W'(1);
  assign bank_base  = {dbr, operand[OFS_W-1:0]};
  assign abs_x_sum  = bank_base + ADDR_W'(xi);
  assign abs_y_sum  = bank_base + ADDR_W'(yi);
  assign long_x_sum = operand + ADDR_W'(xi);
  assign ptr_base   = dp_sum;

  always_comb begin
    unique case (mode)
      AM_PC_STEP: ea = {pbr, pc_next};
      AM_DIR:     ea = {{BANK_W{1'b0}}, dp_sum};
      AM_DIR_X:   ea = {{BANK_W{1'b0}}, dp_x_sum};
      AM_STACK:   ea = {{BANK_W{1'b0}}, sp};
      AM_ABS_X:   ea = abs_x_sum;
      AM_ABS_Y:   ea = abs_y_sum;
      AM_LONG_X:  ea = long_x_sum;
      default:    ea = '0;
    endcase
  end

endmodule

// File: rtl/eag_ptr_fetch.sv
module eag_ptr_fetch #(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     launch,
  input  logic [OFS_W-1:0]         base,
  output logic                     mem_req,
  output logic [OFS_W+BANK_W-1:0]  mem_addr,
  input  logic                     mem_valid,
  input  logic [BYTE_W-1:0]        mem_data,
  output logic                     busy,
  output logic                     ptr_valid,
  output logic [OFS_W+BANK_W-1:0]  ptr
);
  localparam int ADDR_W = OFS_W + BANK_W;
  localparam int NBYTES = ADDR_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  typedef enum logic [1:0] {F_IDLE, F_READ, F_DONE} fstate_t;

  fstate_t          st;
  logic [CNT_W-1:0] cnt;
  logic [OFS_W-1:0] base_q;
  logic [BYTE_W-1:0] byte_q [NBYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      cnt       <= '0;
      base_q    <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      ptr_valid <= 1'b0;
    end else begin
      ptr_valid <= 1'b0;
      unique case (st)
        F_IDLE: if (launch) begin
          st       <= F_READ;
          cnt      <= '0;
          base_q   <= base;
          mem_req  <= 1'b1;
          mem_addr <= {{BANK_W{1'b0}}, base};
        end
        F_READ: if (mem_valid) begin
          if (cnt == LAST) begin
            st        <= F_DONE;
            mem_req   <= 1'b0;
            ptr_valid <= 1'b1;
          end else begin
            cnt      <= cnt + CNT_W'(1);
            mem_addr <= {{BANK_W{1'b0}}, base_q + OFS_W'(cnt) + OFS_W'(1)};
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == F_READ && mem_valid) byte_q[cnt] <= mem_data;
  end

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
      assign ptr[g*BYTE_W +: BYTE_W] = byte_q[g];
    end
  endgenerate

  assign busy = (st != F_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R8
  AST_REQ_BANK0: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ADDR_W-1:OFS_W] == '0)); // R8
  AST_PTR_PULSE: assert property (@(posedge clk) disable iff (rst)
    ptr_valid |=> !ptr_valid); // R10

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import eag_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [2:0]               mode,
  input  logic [OFS_W+BANK_W-1:0]  operand,
  input  logic [OFS_W-1:0]         pc,
  input  logic [BANK_W-1:0]        pbr,
  input  logic [BANK_W-1:0]        dbr,
  input  logic [OFS_W-1:0]         dpr,
  input  logic [OFS_W-1:0]         sp,
  input  logic [OFS_W-1:0]         xr,
  input  logic [OFS_W-1:0]         yr,
  input  logic                     idx8,
  output logic                     mem_req,
  output logic [OFS_W+BANK_W-1:0]  mem_addr,
  input  logic                     mem_valid,
  input  logic [BYTE_W-1:0]        mem_data,
  output logic [OFS_W+BANK_W-1:0]  addr_out,
  output logic                     done
);
  localparam int ADDR_W = OFS_W + BANK_W;
  localparam int NIDX   = 2;

  amode_t            am;
  logic [OFS_W-1:0]  idx_raw [NIDX];
  logic [OFS_W-1:0]  idx_eff [NIDX];
  logic [ADDR_W-1:0] ea;
  logic [OFS_W-1:0]  ptr_base;
  logic              busy;
  logic              ptr_valid;
  logic [ADDR_W-1:0] ptr;
  logic              accept;
  logic              launch;
  logic [OFS_W-1:0]  y_q;

  assign am         = amode_t'(mode);
  assign idx_raw[0] = xr;
  assign idx_raw[1] = yr;

  generate
    for (genvar i = 0; i < NIDX; i++) begin : g_idx
      eag_index_sel #(.W(OFS_W)) u_sel (
        .raw    (idx_raw[i]),
        .narrow (idx8),
        .eff    (idx_eff[i])
      );
    end
  endgenerate

  eag_calc #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_calc (
    .mode     (am),
    .operand  (operand),
    .pc       (pc),
    .pbr      (pbr),
    .dbr      (dbr),
    .dpr      (dpr),
    .sp       (sp),
    .xi       (idx_eff[0]),
    .yi       (idx_eff[1]),
    .ea       (ea),
    .ptr_base (ptr_base)
  );

  assign accept = start && !busy;
  assign launch = accept && (am == AM_IND_LY);

  eag_ptr_fetch #(.OFS_W(OFS_W), .BANK_W(BANK_W), .BYTE_W(BYTE_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .base      (ptr_base),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_data  (mem_data),
    .busy      (busy),
    .ptr_valid (ptr_valid),
    .ptr       (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      done     <= 1'b0;
      y_q      <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        y_q <= idx_eff[1];
      end else if (accept) begin
        addr_out <= ea;
        done     <= 1'b1;
      end
      if (ptr_valid) begin
        addr_out <= ptr + ADDR_W'(y_q);
        done     <= 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_PC_BANK: assert property (@(posedge clk) disable iff (rst)
    (accept && am == AM_PC_STEP) |=> (addr_out[ADDR_W-1:OFS_W] == $past(pbr))); // R1
  AST_DP_BANK0: assert property (@(posedge clk) disable iff (rst)
    (accept && (am == AM_DIR || am == AM_DIR_X)) |=> (addr_out[ADDR_W-1:OFS_W] == '0)); // R2
  AST_STACK_ADDR: assert property (@(posedge clk) disable iff (rst)
    (accept && am == AM_STACK) |=> (addr_out == {{BANK_W{1'b0}}, $past(sp)})); // R4
  AST_SIMPLE_NOREQ: assert property (@(posedge clk) disable iff (rst)
    (accept && am != AM_IND_LY) |=> (done && !mem_req)); // R10

endmodule

// File: tb/tb_bank_addr_gen.sv
`timescale 1ns/1ps
module tb_bank_addr_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [23:0] operand = '0;
  logic [15:0] pc = '0, dpr = '0, sp = '0, xr = '0, yr = '0;
  logic [7:0]  pbr = '0, dbr = '0;
  logic        idx8 = 1'b0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_data = '0;
  logic [23:0] addr_out;
  logic        done;

  int n_checks = 0;
  int n_errors = 0;
  int done_cnt = 0;
  int log_n = 0;
  logic [23:0] req_log [8];
  logic [7:0]  mem [256];

  always #2.5 clk = ~clk;

  bank_addr_gen dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
    .pc(pc), .pbr(pbr), .dbr(dbr), .dpr(dpr), .sp(sp), .xr(xr), .yr(yr),
    .idx8(idx8), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data),
    .addr_out(addr_out), .done(done)
  );

  // Byte responder: answers each request one half-cycle later, then drops valid.
  always @(negedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
    end else if (mem_req && !mem_valid) begin
      mem_valid <= 1'b1;
      mem_data  <= mem[mem_addr[7:0]];
      if (log_n < 8) req_log[log_n] <= mem_addr;
      log_n <= log_n + 1;
    end else begin
      mem_valid <= 1'b0;
    end
    if (!rst && done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic run_simple(input logic [2:0] m, input logic [23:0] op,
                            input logic [23:0] exp, input string tag);
    @(negedge clk);
    mode = m; operand = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, {tag, " done"}, 24'(done), 24'd1);
    chk(addr_out == exp, {tag, " addr"}, addr_out, exp);
    @(negedge clk);
    chk(done == 1'b0, {tag, " done pulse"}, 24'(done), 24'd0);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R11 done", 24'(done), 24'd0);
    chk(mem_req == 1'b0, "R11 mem_req", 24'(mem_req), 24'd0);
    chk(mem_addr == 24'h0, "R11 mem_addr", mem_addr, 24'h0);
    chk(addr_out == 24'h0, "R11 addr_out", addr_out, 24'h0);
  endtask

  task automatic t_pc_step();
    pbr = 8'h01; pc = 16'hFFFF; dbr = 8'h3C;
    run_simple(3'd0, 24'h0, 24'h010000, "R1 wrap");
    pbr = 8'h7F; pc = 16'h1234;
    run_simple(3'd0, 24'h0, 24'h7F1235, "R1 plain");
  endtask

  task automatic t_direct();
    dbr = 8'h55; dpr = 16'hC200;
    run_simple(3'd1, 24'hABCD00, 24'h00C200, "R2 relocated");
    dpr = 16'hFFF0;
    run_simple(3'd1, 24'h000020, 24'h000010, "R2 wrap");
    dpr = 16'h1000; xr = 16'h0005; idx8 = 1'b0;
    run_simple(3'd2, 24'h000010, 24'h001015, "R3 plain");
    dpr = 16'hFF00; xr = 16'h0101;
    run_simple(3'd2, 24'h0000FF, 24'h000100, "R3 wrap");
  endtask

  task automatic t_stack();
    dbr = 8'hAA; sp = 16'h01FF;
    run_simple(3'd3, 24'h123456, 24'h0001FF, "R4 stack");
  endtask

  task automatic t_absolute();
    idx8 = 1'b0; dbr = 8'h01; xr = 16'h0002;
    run_simple(3'd4, 24'h008000, 24'h018002, "R5 abs x");
    xr = 16'hFFFF;
    run_simple(3'd4, 24'h008000, 24'h027FFF, "R5 bank carry");
    dbr = 8'hFF; yr = 16'h0010;
    run_simple(3'd5, 24'h00FFF8, 24'h000008, "R5 abs y wrap24");
  endtask

  task automatic t_long();
    idx8 = 1'b0; dbr = 8'h77; xr = 16'hFFFF;
    run_simple(3'd6, 24'h02FFFF, 24'h03FFFE, "R6 long carry");
    xr = 16'h0002;
    run_simple(3'd6, 24'hFFFFFF, 24'h000001, "R6 wrap24");
  endtask

  task automatic t_idx8();
    idx8 = 1'b1; dbr = 8'h01; xr = 16'h12FF;
    run_simple(3'd4, 24'h008000, 24'h0180FF, "R7 abs x narrow");
    xr = 16'hABCD;
    run_simple(3'd6, 24'h02FFFF, 24'h0300CC, "R7 long narrow");
    dpr = 16'h2000; xr = 16'hFF10;
    run_simple(3'd2, 24'h000001, 24'h002011, "R7 dir x narrow");
    idx8 = 1'b0;
  endtask

  task automatic run_ind(input logic [15:0] dp_v, input logic [7:0] op,
                         input logic [15:0] y_v, input logic n8,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [23:0] exp, input logic [15:0] a0,
                         input bit intrude, input string tag);
    int start_done;
    bit seen;
    seen = 1'b0;
    dpr = dp_v; yr = y_v; idx8 = n8; dbr = 8'h99;
    mem[a0[7:0]] = b0;
    mem[8'(a0[7:0] + 8'd1)] = b1;
    mem[8'(a0[7:0] + 8'd2)] = b2;
    @(negedge clk);
    log_n = 0;
    start_done = done_cnt;
    mode = 3'd7; operand = {16'hEEEE, op}; start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (intrude && i == 2) begin
        mode = 3'd1; operand = 24'h000001; start = 1'b1;
      end
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    start = 1'b0;
    yr = 16'h7777;
    chk(seen, {tag, " R10 done seen"}, 24'(seen), 24'd1);
    chk(addr_out == exp, {tag, " R9 addr"}, addr_out, exp);
    chk(log_n == 3, {tag, " R8 read count"}, 24'(log_n), 24'd3);
    chk(req_log[0] == {8'h00, a0}, {tag, " R8 byte0 addr"}, req_log[0], {8'h00, a0});
    chk(req_log[1] == {8'h00, 16'(a0 + 16'd1)}, {tag, " R8 byte1 addr"}, req_log[1], {8'h00, 16'(a0 + 16'd1)});
    chk(req_log[2] == {8'h00, 16'(a0 + 16'd2)}, {tag, " R8 byte2 addr"}, req_log[2], {8'h00, 16'(a0 + 16'd2)});
    repeat (4) @(negedge clk);
    chk(done_cnt - start_done == 1, {tag, " R10 single done"}, 24'(done_cnt - start_done), 24'd1);
    chk(addr_out == exp, {tag, " R10 result kept"}, addr_out, exp);
  endtask

  task automatic t_indirect();
    run_ind(16'h0010, 8'h20, 16'h0100, 1'b0, 8'h56, 8'h34, 8'h12,
            24'h123556, 16'h0030, 1'b0, "R9 basic");
    run_ind(16'hFFFE, 8'h01, 16'h0001, 1'b0, 8'hFF, 8'hFF, 8'hFF,
            24'h000000, 16'hFFFF, 1'b0, "R8 wrap");
    run_ind(16'h0040, 8'h00, 16'h3480, 1'b1, 8'h90, 8'h00, 8'h05,
            24'h050110, 16'h0040, 1'b1, "R7 R10 narrow intrude");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 24'h0, 24'h0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pc_step();
    t_direct();
    t_stack();
    t_absolute();
    t_long();
    t_idx8();
    t_indirect();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule